// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs complete serial NOR flash commands over a single-line SPI link (one data line out, one in). Software writes each outgoing byte of a command into a transmit byte queue: the opcode, the address bytes most significant first, then any payload. A single write to the control word then sets the target chip, the number of idle clocks to insert and the number of bytes to read back, and launches the command.

Once launched, the engine drops the chosen chip select and clocks out every queued byte, MSB first, in SPI mode 0. SCLK idles low, the data out line changes after a falling edge, and the data in line is sampled on a rising edge. After the bytes it gives the programmed number of idle clocks with the data out line low, then clocks in the requested number of bytes into a receive byte queue. At the end it releases chip select.

Software follows progress only through the two queue fill counts. A write-type command is done when the transmit count is zero. A read-type command is done when the receive count equals the requested length. Received bytes are then taken one per read of the data word. SCLK runs at the system clock divided by `2*CLK_HALF_DIV`, and `CLK_HALF_DIV` must be at least 2.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset every register reads zero. Word 0x0 reads back what was last written to it. Its fields are: bit 0 soft reset, bit 1 enable, bit 2 start, bits [5:4] chip index, bits [15:8] idle-clock count, bits [25:16] read-back byte count. Word 0x4 gives the receive fill count in bits [9:0] and the transmit fill count in bits [21:12].
- R2: A write to word 0x8 appends its bits [7:0] to the transmit queue. A write made while the transmit queue holds FIFO_DEPTH bytes is dropped.
- R3: A write to word 0x0 with enable=1, start=1 and reset=0, made while the engine is idle, sends every queued byte in queue order, MSB first, one bit per SCLK rising edge. Consecutive rising edges are 2*CLK_HALF_DIV clocks apart.
- R4: After the last transmit byte, the engine gives exactly the idle-clock count of SCLK cycles, with the data out line low.
- R5: Next, the engine clocks in the read-back count of bytes, MSB first, from the data in line. At the end the receive count equals the requested length. Each read of word 0x8 returns the oldest received byte in bits [7:0] and removes it.
- R6: Chip select stays low until the falling edge after the last clock of the command. It then goes high with SCLK low. The transmit count reaches zero only once the last transmit byte has been fully clocked.
- R7: Chip index values 0 to NUM_CS-1 pull low only the matching csN line. A larger index pulls none. At most one line is ever low.
- R8: A start written without enable launches nothing. No SCLK edges occur, chip select stays high and the transmit queue is unchanged.
- R9: Writing word 0x0 during a command with start, enable or both cleared ends the command at once. Chip select goes high and SCLK goes low, and no further clocks follow.
- R10: While the soft reset bit is 1, both queues are emptied, the engine is idle and writes to word 0x8 are dropped.
- R11: Reading word 0x8 with an empty receive queue returns zero and leaves both counts unchanged.
- R12: Bytes clocked in while the receive queue is full are dropped. The command still runs its full number of read-back clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Byte address of the register word (0x0, 0x4, 0x8) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; data appears on regRdata the next cycle |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
Two situations are hard to reach from the ports. The first is ending a command partway through, since the write to the control word has to land while clocks are still running. The bench waits a fixed number of cycles after launch, checks that edges have started, then clears start and checks that chip select and SCLK go idle and stay there. The second is receive overflow. The bench runs this through a reduced queue depth of 8 and requests ten read-back bytes. It also sweeps chip index, byte count, idle clocks and read length together, predicting every bit on the wire from arithmetic byte patterns.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int ACT_CS_LSB     = 4;
  localparam int ACT_CS_W       = 2;
  localparam int ACT_IDLE_LSB   = 8;
  localparam int ACT_IDLE_W     = 8;
  localparam int ACT_RB_LSB     = 16;
  localparam int ACT_RB_W       = 10;
  localparam int CNT_FIELD_W    = 10;
  localparam int TXCNT_LSB      = 12;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TX    = 2'd1,
    PH_DUMMY = 2'd2,
    PH_RX    = 2'd3
  } phase_e;

  // control -> datapath strobes (busy and driveTx are levels)
  typedef struct packed {
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic loadHead;
    logic shiftTx;
    logic sampleIn;
    logic sclkRise;
    logic sclkLow;
    logic driveTx;
    logic busy;
  } strobe_t;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushOk = push && (count != CNT_W'(DEPTH));
  assign popOk  = pop && (count != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (push && count == CNT_W'(DEPTH) && !pop && !flush) |=> count == $past(count)); // R12
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (pop && count == '0 && !push && !flush) |=> count == '0); // R11
endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int FIFO_DEPTH   = 512,
  parameter int CLK_HALF_DIV = 2,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int DIV_W = $clog2(CLK_HALF_DIV + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic [7:0]          rxHead,
  output strobe_t             strb,
  output logic [ACT_CS_W-1:0] csSel
);
  logic [31:0] actWord;
  phase_e      phase;
  logic [DIV_W-1:0] divCnt;
  logic        sclkHigh;
  logic [2:0]  bitCnt;
  logic [ACT_IDLE_W-1:0] idleLeft;
  logic [ACT_RB_W-1:0]   rbLeft;
  logic        reloadPend;

  logic selAct, selCnt, selData, actWr;
  logic launchReq, abortReq, tick, riseTick, fallTick, byteEnd, txLast;
  logic [ACT_IDLE_W-1:0] wIdle;
  logic [ACT_RB_W-1:0]   wRb;

  assign selAct  = (regAddr == 4'h0);
  assign selCnt  = (regAddr == 4'h4);
  assign selData = (regAddr == 4'h8);
  assign actWr   = regWr && selAct;
  assign wIdle   = regWdata[ACT_IDLE_LSB +: ACT_IDLE_W];
  assign wRb     = regWdata[ACT_RB_LSB +: ACT_RB_W];

  assign launchReq = actWr && regWdata[2] && regWdata[1] && !regWdata[0] && (phase == PH_IDLE);
  assign abortReq  = actWr && (phase != PH_IDLE) && (!regWdata[2] || !regWdata[1] || regWdata[0]);
  assign tick      = (phase != PH_IDLE) && (divCnt == DIV_W'(CLK_HALF_DIV - 1));
  assign riseTick  = tick && !sclkHigh;
  assign fallTick  = tick && sclkHigh;
  assign byteEnd   = fallTick && (bitCnt == 3'd7);
  assign txLast    = (txCount == CNT_W'(1));
  assign csSel     = actWord[ACT_CS_LSB +: ACT_CS_W];

  always_comb begin
    strb          = '0;
    strb.flush    = actWord[0];
    strb.txPush   = regWr && selData && !actWord[0];
    strb.rxPop    = regRd && selData && (rxCount != '0);
    strb.loadHead = (launchReq && txCount != '0) || reloadPend;
    strb.sclkRise = riseTick;
    strb.sclkLow  = fallTick || abortReq;
    strb.sampleIn = riseTick && (phase == PH_RX);
    strb.txPop    = byteEnd && (phase == PH_TX);
    strb.shiftTx  = fallTick && !byteEnd && (phase == PH_TX);
    strb.rxPush   = byteEnd && (phase == PH_RX);
    strb.driveTx  = (phase == PH_TX);
    strb.busy     = (phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actWord    <= '0;
      regRdata   <= '0;
      phase      <= PH_IDLE;
      divCnt     <= '0;
      sclkHigh   <= 1'b0;
      bitCnt     <= '0;
      idleLeft   <= '0;
      rbLeft     <= '0;
      reloadPend <= 1'b0;
    end else begin
      if (actWr) actWord <= regWdata;

      if (regRd) begin
        case (1'b1)
          selAct:  regRdata <= actWord;
          selCnt:  regRdata <= {10'd0, CNT_FIELD_W'(txCount), 2'd0, CNT_FIELD_W'(rxCount)};
          selData: regRdata <= {24'd0, (rxCount != '0) ? rxHead : 8'h00};
          default: regRdata <= '0;
        endcase
      end

      reloadPend <= 1'b0;
      if (actWord[0] || abortReq) begin
        phase    <= PH_IDLE;
        divCnt   <= '0;
        sclkHigh <= 1'b0;
        bitCnt   <= '0;
      end else if (launchReq) begin
        idleLeft <= wIdle;
        rbLeft   <= wRb;
        bitCnt   <= '0;
        divCnt   <= '0;
        sclkHigh <= 1'b0;
        if (txCount != '0)      phase <= PH_TX;
        else if (wIdle != '0)   phase <= PH_DUMMY;
        else if (wRb != '0)     phase <= PH_RX;
        else                    phase <= PH_IDLE;
      end else if (phase != PH_IDLE) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (riseTick) sclkHigh <= 1'b1;
        if (fallTick) begin
          sclkHigh <= 1'b0;
          case (phase)
            PH_TX: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) begin
                if (!txLast)             reloadPend <= 1'b1;
                else if (idleLeft != '0) phase <= PH_DUMMY;
                else if (rbLeft != '0)   phase <= PH_RX;
                else                     phase <= PH_IDLE;
              end
            end
            PH_DUMMY: begin
              idleLeft <= idleLeft - 1'b1;
              if (idleLeft == ACT_IDLE_W'(1)) phase <= (rbLeft != '0) ? PH_RX : PH_IDLE;
            end
            PH_RX: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) begin
                rbLeft <= rbLeft - 1'b1;
                if (rbLeft == ACT_RB_W'(1)) phase <= PH_IDLE;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    actWord[0] |-> !strb.busy); // R10
  AST_LAUNCH_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.busy) |-> (actWord[1] && actWord[2])); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !strb.busy); // R9
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int NUM_CS     = 3,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [7:0]          pushByte,
  input  logic [ACT_CS_W-1:0] csSel,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic [NUM_CS-1:0]   csN,
  output logic [CNT_W-1:0]    txCount,
  output logic [CNT_W-1:0]    rxCount,
  output logic [7:0]          rxHead
);
  logic [7:0] txHead, shiftOutQ, shiftInQ;
  logic       sclkQ;

  sfc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.txPush), .pushData(pushByte), .pop(strb.txPop),
    .head(txHead), .count(txCount)
  );

  sfc_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.rxPush), .pushData(shiftInQ), .pop(strb.rxPop),
    .head(rxHead), .count(rxCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftOutQ <= '0;
      shiftInQ  <= '0;
      sclkQ     <= 1'b0;
    end else begin
      if (strb.loadHead)     shiftOutQ <= txHead;
      else if (strb.shiftTx) shiftOutQ <= {shiftOutQ[6:0], 1'b0};
      if (strb.sampleIn)     shiftInQ  <= {shiftInQ[6:0], miso};
      if (strb.sclkLow)       sclkQ <= 1'b0;
      else if (strb.sclkRise) sclkQ <= 1'b1;
    end
  end

  assign sclk = sclkQ;
  assign mosi = strb.driveTx & shiftOutQ[7];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(strb.busy && (csSel == ACT_CS_W'(g)));
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> !sclkQ); // R6
  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (csN != {NUM_CS{1'b1}}) |-> (strb.busy && $onehot0(~csN))); // R7
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfc_pkg::*;
#(
  parameter int FIFO_DEPTH   = 512,
  parameter int NUM_CS       = 3,
  parameter int CLK_HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  strobe_t             strb;
  logic [ACT_CS_W-1:0] csSel;
  logic [CNT_W-1:0]    txCount, rxCount;
  logic [7:0]          rxHead;

  sfc_control #(.FIFO_DEPTH(FIFO_DEPTH), .CLK_HALF_DIV(CLK_HALF_DIV)) u_control (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead), .strb(strb), .csSel(csSel)
  );

  sfc_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .pushByte(regWdata[7:0]), .csSel(csSel),
    .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead)
  );
endmodule

// File: tb/sflash_cmd_engine_tb.sv
module sflash_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NCS   = 3;
  localparam int HALF  = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic sclk, mosi, miso;
  logic [NCS-1:0] csN;

  int nChk = 0, nBad = 0;
  int riseCnt = 0, curNsent = 0, curIdle = 0;
  logic mosiCap [256];
  time lastRiseT = 0;
  bit periodErr = 0, csChanged = 0, csUpSeen = 0, sclkAtCsUp = 0;
  logic [2:0] csAtRise = '1;
  int riseAtCsUp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_cmd_engine #(.FIFO_DEPTH(DEPTH), .NUM_CS(NCS), .CLK_HALF_DIV(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  function automatic logic [7:0] txByte(input int i, input int n);
    return 8'((i * 41 + n * 17 + 3) & 255);
  endfunction
  function automatic logic [7:0] rbByte(input int k);
    return 8'((k * 59 + 92) & 255);
  endfunction
  function automatic logic misoBit(input int r, input int ns, input int di);
    logic [7:0] b;
    int j;
    if (r < 8 * ns + di) return 1'b0;
    j = r - (8 * ns + di);
    b = rbByte(j / 8);
    return b[7 - (j % 8)];
  endfunction

  assign miso = misoBit(riseCnt, curNsent, curIdle);

  always @(posedge sclk) begin
    if (riseCnt > 0 && ($time - lastRiseT) != 2 * HALF * CLK_PERIOD) periodErr = 1;
    lastRiseT = $time;
    if (riseCnt < 256) mosiCap[riseCnt] = mosi;
    if (riseCnt == 0) csAtRise = csN;
    else if (csN != csAtRise) csChanged = 1;
    riseCnt = riseCnt + 1;
  end

  wire csAllHigh = &csN;
  always @(posedge csAllHigh) begin
    csUpSeen = 1;
    riseAtCsUp = riseCnt;
    sclkAtCsUp = sclk;
  end

  task automatic chk(input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    v = regRdata;
  endtask

  task automatic runTxn(input int cs, input int npush, input int idle, input int rb);
    int nsent, nrx, total, bad;
    logic [31:0] d;
    logic [7:0] tb;
    nsent = (npush < DEPTH) ? npush : DEPTH;
    nrx   = (rb < DEPTH) ? rb : DEPTH;
    total = 8 * nsent + idle + 8 * rb;
    for (int i = 0; i < npush; i++) regWrite(4'h8, 32'(txByte(i, npush)));
    regRead(4'h4, d);
    chk("R2 tx fill count", int'(d[21:12]), nsent);
    curNsent = nsent; curIdle = idle;
    riseCnt = 0; periodErr = 0; csChanged = 0; csUpSeen = 0;
    regWrite(4'h0, (32'(rb) << 16) | (32'(idle) << 8) | (32'(cs) << 4) | 32'h6);
    repeat (total * 2 * HALF + 8) @(negedge clk);
    chk("R3 clock count", riseCnt, total);
    bad = 0;
    for (int i = 0; i < nsent; i++) begin
      tb = txByte(i, npush);
      for (int b = 0; b < 8; b++) if (mosiCap[i * 8 + b] !== tb[7 - b]) bad++;
    end
    chk("R3 mosi bit errors", bad, 0);
    bad = 0;
    for (int k = 0; k < idle; k++) if (mosiCap[8 * nsent + k] !== 1'b0) bad++;
    if (idle > 0) chk("R4 idle clocks mosi low", bad, 0);
    chk("R3 sclk period", int'(periodErr), 0);
    if (total > 0) begin
      chk("R7 cs pattern", int'(csAtRise), (cs < NCS) ? (7 & ~(1 << cs)) : 7);
      chk("R7 cs stable", int'(csChanged), 0);
      if (cs < NCS) begin
        chk("R6 cs rise seen", int'(csUpSeen), 1);
        chk("R6 clocks before cs rise", riseAtCsUp, total);
        chk("R6 sclk low at cs rise", int'(sclkAtCsUp), 0);
      end
    end
    chk("R6 idle lines", int'({csN, sclk}), 4'b1110);
    regRead(4'h4, d);
    chk("R6 tx count zero", int'(d[21:12]), 0);
    chk("R5 R12 rx count", int'(d[9:0]), nrx);
    bad = 0;
    for (int k = 0; k < nrx; k++) begin
      regRead(4'h8, d);
      if (d != 32'(rbByte(k))) bad++;
    end
    if (nrx > 0) chk("R5 rx byte errors", bad, 0);
    regRead(4'h4, d);
    chk("R5 rx drained", int'(d[9:0]), 0);
    regWrite(4'h0, 32'h2);
  endtask

  initial begin
    logic [31:0] d;
    int r;
    int ntxSet[4] = '{0, 1, 2, 5};
    int idleSet[3] = '{0, 3, 8};
    int rbSet[4] = '{0, 1, 3, 10};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6 reset lines", int'({csN, sclk}), 4'b1110);
    regRead(4'h0, d); chk("R1 action reset", int'(d), 0);
    regRead(4'h4, d); chk("R1 count reset", int'(d), 0);
    regRead(4'h8, d); chk("R11 empty pop data", int'(d), 0);
    regRead(4'h4, d); chk("R11 counts after empty pop", int'(d), 0);
    regWrite(4'h0, 32'h0003_0A32);
    regRead(4'h0, d); chk("R1 action readback", int'(d), 32'h0003_0A32);
    chk("R1 no launch without start", int'(csN), 7);
    regWrite(4'h0, 32'h2);

    // R8: start without enable
    regWrite(4'h8, 32'h11); regWrite(4'h8, 32'h22);
    riseCnt = 0;
    regWrite(4'h0, 32'h4);
    repeat (40) @(negedge clk);
    chk("R8 no clocks", riseCnt, 0);
    chk("R8 cs high", int'(csN), 7);
    regRead(4'h4, d); chk("R8 tx count kept", int'(d[21:12]), 2);

    // R10: soft reset
    regWrite(4'h0, 32'h3);
    regRead(4'h4, d); chk("R10 flushed", int'(d), 0);
    regWrite(4'h8, 32'h55);
    regRead(4'h4, d); chk("R10 push dropped", int'(d), 0);
    regWrite(4'h0, 32'h2);
    regWrite(4'h8, 32'h55);
    regRead(4'h4, d); chk("R10 push after release", int'(d[21:12]), 1);
    regWrite(4'h0, 32'h1); regWrite(4'h0, 32'h2);

    // R9: abort mid command
    for (int i = 0; i < 4; i++) regWrite(4'h8, 32'(txByte(i, 4)));
    curNsent = 4; curIdle = 0; riseCnt = 0;
    regWrite(4'h0, 32'h16);
    repeat (20) @(negedge clk);
    chk("R9 command in progress", int'(riseCnt > 0), 1);
    regWrite(4'h0, 32'h2);
    chk("R9 cs high after abort", int'(csN), 7);
    chk("R9 sclk low after abort", int'(sclk), 0);
    r = riseCnt;
    repeat (40) @(negedge clk);
    chk("R9 no further clocks", riseCnt, r);
    regWrite(4'h0, 32'h1); regWrite(4'h0, 32'h2);
    regRead(4'h4, d); chk("R10 flush after abort", int'(d), 0);

    // R2 transmit overflow and a fast-read style command
    runTxn(0, 10, 0, 0);
    runTxn(2, 5, 8, 8);

    // sweep
    for (int cs = 0; cs < 4; cs++)
      foreach (ntxSet[a])
        foreach (idleSet[b])
          foreach (rbSet[c])
            runTxn(cs, ntxSet[a], idleSet[b], rbSet[c]);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule